// File: doc/BRIEF.md
# Page Versus Buffer Comparator

This engine checks whether one page of the non-volatile main array holds the same bytes as one of the two page-sized staging buffers. A start pulse gives it a buffer choice and a 12-bit page number. It then walks every byte position of the page once. It drives the same byte address to the main array and to the chosen buffer through two synchronous read ports, and each port returns its data one cycle later.

Any difference between a returned pair, even a single bit, is accumulated. Busy stays high from the cycle after the start until the verdict is produced. The busy time can be stretched by a parameter so that it models a slower array. On completion a one-cycle done pulse appears together with a fresh verdict bit. The verdict stays unchanged until the next compare completes. An abort input ends a compare early and leaves the earlier verdict in place.

Top module: `pgbuf_cmp`

## Requirements
- R1: A high `start_i` while idle captures `buf_sel_i` and `page_i`. In the next cycle `busy_o` and `rd_en_o` are high, `rd_addr_o` is 0, and `rd_page_o`/`rd_buf_o` carry the captured values.
- R2: During a compare, `rd_en_o` is high for exactly PAGE_BYTES consecutive cycles. `rd_addr_o` steps 0, 1, …, PAGE_BYTES-1, one address per cycle.
- R3: Every byte pair, the first and the last included, counts toward the verdict. Each pair is taken from the read data one cycle after its address was issued.
- R4: `busy_o` stays high for PAGE_BYTES+1+PAD_CYCLES cycles. In the cycle after the last busy cycle, `done_o` is high for one cycle while `busy_o` is low.
- R5: At the done pulse, `mismatch_o` becomes 0 if all pairs were equal and 1 if any bit differed. At every other time it holds its value, so a 1 is not sticky across compares.
- R6: A `start_i` pulse while busy is ignored. The running compare keeps its page, buffer, address sequence and length.
- R7: A high `abort_i` while busy returns the engine to idle in the next cycle with no done pulse, no further reads and `mismatch_o` unchanged.
- R8: While `rst_n` is low, `busy_o`, `done_o`, `mismatch_o` and `rd_en_o` are 0.
- R9: `buf_sel_i` = 0 selects the first buffer and 1 the second. The choice appears on `rd_buf_o` for the whole read phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a compare (taken only while idle) |
| buf_sel_i | input | 1 | Buffer choice: 0 first, 1 second |
| page_i | input | PAGE_AW | Page number to compare |
| abort_i | input | 1 | Terminate the running compare |
| rd_en_o | output | 1 | Read strobe to array and buffer |
| rd_addr_o | output | BYTE_AW | Byte address within page/buffer |
| rd_page_o | output | PAGE_AW | Page number on the array read port |
| rd_buf_o | output | 1 | Which buffer is read |
| arr_rdata_i | input | DATA_W | Array byte, one cycle after the strobe |
| buf_rdata_i | input | DATA_W | Buffer byte, one cycle after the strobe |
| busy_o | output | 1 | Compare in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mismatch_o | output | 1 | Latched verdict: 1 means some bit differed |

## Verification
The bench places a single flipped bit at byte 0 and then at the last byte. A design that misjudged the one-cycle read latency, or stopped one address early, would report a match in one of those cases. A differing compare is followed by a matching one to expose a verdict that never clears. Aborts land both in the read phase and in the padding phase. A design that latched a partial verdict or pulsed done would be caught, and so would a stray start during busy that restarted or re-targeted the walk.

// File: rtl/pgbuf_cmp_pkg.sv
package pgbuf_cmp_pkg;
   typedef enum logic [1:0] {
      CMP_IDLE  = 2'd0,
      CMP_SCAN  = 2'd1,
      CMP_DRAIN = 2'd2,
      CMP_PAD   = 2'd3
   } cmp_state_e;
endpackage

// File: rtl/pgbuf_cmp_addrgen.sv
// Byte-position counter for the read walk.
module pgbuf_cmp_addrgen #(
   parameter int PAGE_BYTES = 264,
   parameter int AW         = $clog2(PAGE_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          adv_i,
   output logic [AW-1:0] addr_o,
   output logic          last_o
);
   localparam logic [AW-1:0] LAST_ADDR = AW'(PAGE_BYTES - 1);

   logic [AW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (adv_i)  cnt_q <= cnt_q + 1'b1;
   end

   assign addr_o = cnt_q;
   assign last_o = (cnt_q == LAST_ADDR);

   // R2: each advance moves exactly one position
   assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i && !clr_i |=> addr_o == $past(addr_o) + 1'b1);

   // R2: the walk never leaves the page
   assert_addr_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      addr_o <= LAST_ADDR);
endmodule

// File: rtl/pgbuf_cmp_accum.sv
// Delays the read strobe by the port latency and ORs every lane difference.
module pgbuf_cmp_accum #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              req_i,
   input  logic [DATA_W-1:0] arr_i,
   input  logic [DATA_W-1:0] buf_i,
   output logic              diff_o
);
   logic              vld_q;
   logic              diff_q;
   logic [DATA_W-1:0] lane_diff;
   logic              pair_diff;

   for (genvar g = 0; g < DATA_W; g++) begin : g_lane
      assign lane_diff[g] = arr_i[g] ^ buf_i[g];
   end

   assign pair_diff = vld_q && (|lane_diff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         diff_q <= 1'b0;
      end else begin
         vld_q <= req_i;
         if (clr_i)          diff_q <= 1'b0;
         else if (pair_diff) diff_q <= 1'b1;
      end
   end

   // includes the pair arriving this cycle, so the final byte is never lost
   assign diff_o = diff_q | pair_diff;

   // R3: a seen difference is kept until the next compare clears it
   assert_diff_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      diff_q && !clr_i |=> diff_q);

   // R3: data is only judged in the cycle after a strobe
   assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req_i |=> vld_q);
endmodule

// File: rtl/pgbuf_cmp_pad.sv
// Optional busy-time extension after the last pair is judged.
module pgbuf_cmp_pad #(
   parameter int PAD_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic run_i,
   output logic expire_o
);
   if (PAD_CYCLES == 0) begin : g_nopad
      assign expire_o = 1'b1;
   end else begin : g_pad
      localparam int CW = (PAD_CYCLES > 1) ? $clog2(PAD_CYCLES) : 1;
      localparam logic [CW-1:0] START_VAL = CW'(PAD_CYCLES - 1);

      logic [CW-1:0] left_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     left_q <= '0;
         else if (load_i)                left_q <= START_VAL;
         else if (run_i && left_q != '0) left_q <= left_q - 1'b1;
      end

      assign expire_o = (left_q == '0);

      // R4: the pad counter never exceeds its loaded span
      assert_pad_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
         left_q <= START_VAL);
   end
endmodule

// File: rtl/pgbuf_cmp.sv
module pgbuf_cmp
   import pgbuf_cmp_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int PAGE_BYTES = 264,
   parameter int PAGE_AW    = 12,
   parameter int PAD_CYCLES = 4,
   localparam int BYTE_AW   = $clog2(PAGE_BYTES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               buf_sel_i,
   input  logic [PAGE_AW-1:0] page_i,
   input  logic               abort_i,
   output logic               rd_en_o,
   output logic [BYTE_AW-1:0] rd_addr_o,
   output logic [PAGE_AW-1:0] rd_page_o,
   output logic               rd_buf_o,
   input  logic [DATA_W-1:0]  arr_rdata_i,
   input  logic [DATA_W-1:0]  buf_rdata_i,
   output logic               busy_o,
   output logic               done_o,
   output logic               mismatch_o
);
   localparam bit HAS_PAD = (PAD_CYCLES > 0);

   if (PAGE_BYTES < 2) begin : g_chk_bytes
      $error("pgbuf_cmp: PAGE_BYTES must be at least 2");
   end
   if (DATA_W < 1) begin : g_chk_width
      $error("pgbuf_cmp: DATA_W must be positive");
   end
   if (PAGE_AW < 1) begin : g_chk_page
      $error("pgbuf_cmp: PAGE_AW must be positive");
   end
   if (PAD_CYCLES < 0) begin : g_chk_pad
      $error("pgbuf_cmp: PAD_CYCLES must not be negative");
   end

   cmp_state_e         state_q, state_d;
   logic [PAGE_AW-1:0] page_q;
   logic               sel_q;
   logic               done_q;
   logic               res_q;

   logic accept, scan, last, adv, finish, pad_expire, diff;

   assign accept = (state_q == CMP_IDLE) && start_i;
   assign scan   = (state_q == CMP_SCAN);
   assign adv    = scan && !last;
   assign finish = !abort_i &&
                   (((state_q == CMP_DRAIN) && !HAS_PAD) ||
                    ((state_q == CMP_PAD) && pad_expire));

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         CMP_IDLE:  if (start_i) state_d = CMP_SCAN;
         CMP_SCAN:  if (abort_i) state_d = CMP_IDLE;
                    else if (last) state_d = CMP_DRAIN;
         CMP_DRAIN: if (abort_i) state_d = CMP_IDLE;
                    else state_d = HAS_PAD ? CMP_PAD : CMP_IDLE;
         CMP_PAD:   if (abort_i || pad_expire) state_d = CMP_IDLE;
         default:   state_d = CMP_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CMP_IDLE;
         page_q  <= '0;
         sel_q   <= 1'b0;
         done_q  <= 1'b0;
         res_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= finish;
         if (accept) begin
            page_q <= page_i;
            sel_q  <= buf_sel_i;
         end
         if (finish) res_q <= diff;
      end
   end

   pgbuf_cmp_addrgen #(.PAGE_BYTES(PAGE_BYTES), .AW(BYTE_AW)) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (accept),
      .adv_i  (adv),
      .addr_o (rd_addr_o),
      .last_o (last)
   );

   pgbuf_cmp_accum #(.DATA_W(DATA_W)) u_accum (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (accept),
      .req_i  (scan),
      .arr_i  (arr_rdata_i),
      .buf_i  (buf_rdata_i),
      .diff_o (diff)
   );

   pgbuf_cmp_pad #(.PAD_CYCLES(PAD_CYCLES)) u_pad (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (state_q == CMP_DRAIN),
      .run_i    (state_q == CMP_PAD),
      .expire_o (pad_expire)
   );

   assign rd_en_o    = scan;
   assign rd_page_o  = page_q;
   assign rd_buf_o   = sel_q;
   assign busy_o     = (state_q != CMP_IDLE);
   assign done_o     = done_q;
   assign mismatch_o = res_q;

   // R1: an accepted start opens the walk at byte 0 on the next cycle
   assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o |=> busy_o && rd_en_o && rd_addr_o == '0
                             && rd_page_o == $past(page_i) && rd_buf_o == $past(buf_sel_i));

   // R4: done only appears once busy has dropped
   assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R4: done is a single-cycle pulse
   assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R5: the verdict moves only with a done pulse
   assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(mismatch_o));

   // R6: a start during busy leaves the targets untouched
   assert_busy_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && start_i |=> $stable(rd_page_o) && $stable(rd_buf_o));

   // R7: abort ends the compare silently
   assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && abort_i |=> !busy_o && !done_o && !rd_en_o && $stable(mismatch_o));
endmodule

// File: tb/pgbuf_cmp_tb.sv
`timescale 1ns/1ps
module pgbuf_cmp_tb;
   localparam int DW    = 8;
   localparam int NB    = 264;
   localparam int PAW   = 12;
   localparam int PAD   = 4;
   localparam int BAW   = $clog2(NB);
   localparam int BUSY  = NB + 1 + PAD;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start_i = 1'b0;
   logic           buf_sel_i = 1'b0;
   logic [PAW-1:0] page_i = '0;
   logic           abort_i = 1'b0;
   logic           rd_en_o;
   logic [BAW-1:0] rd_addr_o;
   logic [PAW-1:0] rd_page_o;
   logic           rd_buf_o;
   logic [DW-1:0]  arr_rdata = '0;
   logic [DW-1:0]  buf_rdata = '0;
   logic           busy_o, done_o, mismatch_o;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   pgbuf_cmp #(.DATA_W(DW), .PAGE_BYTES(NB), .PAGE_AW(PAW), .PAD_CYCLES(PAD)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .buf_sel_i(buf_sel_i),
      .page_i(page_i), .abort_i(abort_i), .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o),
      .rd_page_o(rd_page_o), .rd_buf_o(rd_buf_o), .arr_rdata_i(arr_rdata),
      .buf_rdata_i(buf_rdata), .busy_o(busy_o), .done_o(done_o), .mismatch_o(mismatch_o)
   );

   // storage models
   logic [DW-1:0] bufa [NB];
   logic [DW-1:0] bufb [NB];

   function automatic logic [DW-1:0] pat(int pg, int b);
      return DW'((pg * 37 + b * 11 + (pg >> 3)) ^ (b >> 2));
   endfunction

   always @(posedge clk) begin
      if (rd_en_o) begin
         arr_rdata <= pat(int'(rd_page_o), int'(rd_addr_o));
         buf_rdata <= rd_buf_o ? bufb[rd_addr_o] : bufa[rd_addr_o];
      end
   end

   function automatic int calc(bit sel, int pg);
      for (int b = 0; b < NB; b++) begin
         if ((sel ? bufb[b] : bufa[b]) != pat(pg, b)) return 1;
      end
      return 0;
   endfunction

   // reference model
   int m_cnt = 0, m_done = 0, m_res = 0, m_pend = 0, m_sel = 0, m_page = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_done = 0; m_res = 0;
      end else begin
         m_done = 0;
         if (m_cnt > 0) begin
            if (abort_i) m_cnt = 0;
            else begin
               m_cnt--;
               if (m_cnt == 0) begin m_done = 1; m_res = m_pend; end
            end
         end else if (start_i) begin
            m_cnt  = BUSY;
            m_pend = calc(buf_sel_i, int'(page_i));
            m_sel  = int'(buf_sel_i);
            m_page = int'(page_i);
         end
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      int el;
      bit exp_rd;
      el = BUSY - m_cnt;
      exp_rd = (m_cnt > 0) && (el < NB);
      check(busy_o == (m_cnt > 0), "R4 busy", int'(busy_o), int'(m_cnt > 0));
      check(done_o == m_done[0], "R4 done", int'(done_o), m_done);
      check(mismatch_o == m_res[0], "R5 verdict", int'(mismatch_o), m_res);
      check(rd_en_o == exp_rd, "R2 strobe", int'(rd_en_o), int'(exp_rd));
      if (exp_rd) begin
         check(int'(rd_addr_o) == el, "R2 address", int'(rd_addr_o), el);
         check(int'(rd_page_o) == m_page, "R1 page", int'(rd_page_o), m_page);
         check(int'(rd_buf_o) == m_sel, "R9 buffer", int'(rd_buf_o), m_sel);
      end
   end

   task automatic fill(bit sel, int pg);
      for (int b = 0; b < NB; b++) begin
         if (sel) bufb[b] = pat(pg, b); else bufa[b] = pat(pg, b);
      end
   endtask

   task automatic kick(bit sel, int pg);
      @(negedge clk);
      start_i = 1'b1; buf_sel_i = sel; page_i = PAW'(pg);
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic run_cmp(bit sel, int pg, int exp, string tag);
      kick(sel, pg);
      repeat (BUSY + 2) @(negedge clk);
      check(mismatch_o == exp[0], tag, int'(mismatch_o), exp);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      fill(1'b0, 0);
      fill(1'b1, 0);
      repeat (4) @(negedge clk);
      // R8: reset state
      check(!busy_o, "R8 busy in reset", int'(busy_o), 0);
      check(!done_o, "R8 done in reset", int'(done_o), 0);
      check(!mismatch_o, "R8 verdict in reset", int'(mismatch_o), 0);
      check(!rd_en_o, "R8 strobe in reset", int'(rd_en_o), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R5: full match
      fill(1'b0, 5);
      run_cmp(1'b0, 5, 0, "R5 match page 5");

      // R3: last byte differs in second buffer
      fill(1'b1, 12'hABC);
      bufb[NB-1] = bufb[NB-1] ^ 8'h10;
      run_cmp(1'b1, 12'hABC, 1, "R3 last byte diff");

      // R5: verdict clears on next matching compare, top page
      fill(1'b0, 4095);
      run_cmp(1'b0, 4095, 0, "R5 clears after diff");

      // R3: first byte differs
      fill(1'b0, 7);
      bufa[0] = bufa[0] ^ 8'h01;
      run_cmp(1'b0, 7, 1, "R3 first byte diff");

      // R9: buffer choice matters
      fill(1'b0, 9);
      run_cmp(1'b1, 9, 1, "R9 second buffer differs");
      run_cmp(1'b0, 9, 0, "R9 first buffer matches");

      // R7: abort in read phase keeps verdict 0, no done
      kick(1'b1, 100);
      repeat (50) @(negedge clk);
      abort_i = 1'b1;
      @(negedge clk);
      abort_i = 1'b0;
      check(!busy_o && !done_o, "R7 abort scan idle", int'(busy_o), 0);
      repeat (BUSY) @(negedge clk);
      check(!mismatch_o, "R7 verdict kept after scan abort", int'(mismatch_o), 0);

      // R7: abort in padding phase
      kick(1'b1, 100);
      repeat (NB + 2) @(negedge clk);
      abort_i = 1'b1;
      @(negedge clk);
      abort_i = 1'b0;
      repeat (PAD + 3) @(negedge clk);
      check(!mismatch_o, "R7 verdict kept after pad abort", int'(mismatch_o), 0);

      // R6: start while busy ignored
      kick(1'b0, 9);
      repeat (20) @(negedge clk);
      start_i = 1'b1; buf_sel_i = 1'b1; page_i = PAW'(100);
      @(negedge clk);
      start_i = 1'b0;
      repeat (BUSY) @(negedge clk);
      check(!busy_o, "R6 length unchanged", int'(busy_o), 0);
      check(!mismatch_o, "R6 original target judged", int'(mismatch_o), 0);

      repeat (3) @(negedge clk);
      summary();
   end
endmodule